// File: doc/BRIEF.md
# Serial Divisible-by-Five Detector

This block watches a binary number that grows without limit, one bit at a time, most significant bit first. Each accepted bit is appended on the right, so the value so far becomes twice its old value plus the new bit. After every accepted bit the block raises or lowers a flag that tells whether the value so far is a whole multiple of five.

The full value is never stored. A three-bit register holds only the value modulo five, and each bit moves it to `(2*r + bit) mod 5`. As a result, streams of any length are handled without overflow. The verdict is registered. It appears on the clock edge that samples the bit, and it covers that bit.

The input is a one-bit stream qualified by a valid strobe. There is no ready signal, because the block takes a bit on every cycle where valid is high, back to back with no stall. A producer therefore never sees back-pressure. Cycles with valid low are idle and change nothing.

Top module: `serial_div5_detector`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the remainder to zero and drives `is_multiple` low on the following cycle.
- R2: Each bit accepted while `bit_valid` is high becomes the new least significant bit, so the tracked value changes from v to 2v + `bit_in`.
- R3: Streams of unlimited length give correct results. The internal remainder always stays in 0..4, so no overflow can occur.
- R4: `is_multiple` is a registered output. It updates on the edge that samples a valid bit and is high exactly when the value including that bit is divisible by five.
- R5: Feeding the bits 1,0,1,0,1 after reset gives the values 1,2,5,10,21, and `is_multiple` takes the values 0,0,1,1,0.
- R6: A cycle with `bit_valid` low leaves both the remainder and `is_multiple` unchanged.
- R7: A value of zero counts as a multiple. A leading 0 bit after reset drives `is_multiple` high.
- R8: A reset applied in the middle of a stream discards the earlier bits, and the next bit starts a new value from zero.
- R9: There is no back-pressure. Valid bits on consecutive cycles are each accepted, and each gives its own verdict.
- R10: The next remainder can come from modular arithmetic (`STEP_STYLE` = 0) or from a computed lookup table (`STEP_STYLE` = 1). Both give identical outputs for any stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | High when `bit_in` carries a bit to append |
| bit_in | input | 1 | Next serial bit, most significant first |
| is_multiple | output | 1 | High when the value accepted so far is divisible by five |

## Verification
The bench builds two copies of the block side by side, one with `STEP_STYLE` 0 and one with `STEP_STYLE` 1. Both copies receive one stream and are checked against one expected queue, so any disagreement between the arithmetic step and the table step shows up directly. The stream is several thousand bits long with random idle gaps. Its length pushes the tracked value far beyond any fixed width, which exercises every remainder transition, including the wrap from large remainders back to zero.

// File: rtl/div5_pkg.sv
package div5_pkg;
  localparam int unsigned MODULUS = 5;
  localparam int unsigned REM_W   = $clog2(MODULUS);
  localparam int unsigned IDX_W   = REM_W + 1;
  localparam int unsigned LUT_N   = 2 ** IDX_W;

  typedef logic [REM_W-1:0] rem_t;
  typedef logic [IDX_W-1:0] idx_t;

  localparam idx_t MOD_EXT = idx_t'(MODULUS);
endpackage

// File: rtl/div5_step.sv
module div5_step
  import div5_pkg::*;
#(
  parameter int unsigned STEP_STYLE = 0
) (
  input  rem_t rem_i,
  input  logic bit_i,
  output rem_t rem_o,
  output logic zero_o
);
  idx_t shifted;
  assign shifted = {rem_i, bit_i};

  generate
    if (STEP_STYLE == 0) begin : g_arith
      always_comb begin
        if (shifted >= MOD_EXT) rem_o = rem_t'(shifted - MOD_EXT);
        else                    rem_o = rem_t'(shifted);
      end
    end else begin : g_table
      rem_t lut [LUT_N];
      for (genvar i = 0; i < int'(LUT_N); i++) begin : g_entry
        assign lut[i] = rem_t'(i % int'(MODULUS));
      end
      assign rem_o = lut[shifted];
    end
  endgenerate

  assign zero_o = (rem_o == '0);
endmodule

// File: rtl/div5_state.sv
module div5_state
  import div5_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  rem_t rem_next,
  output rem_t rem_q
);
  always_ff @(posedge clk) begin
    if (rst)     rem_q <= '0;
    else if (en) rem_q <= rem_next;
  end
endmodule

// File: rtl/div5_flag.sv
module div5_flag (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic zero_next,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)     flag_q <= 1'b0;
    else if (en) flag_q <= zero_next;
  end
endmodule

// File: rtl/serial_div5_detector.sv
module serial_div5_detector
  import div5_pkg::*;
#(
  parameter int unsigned STEP_STYLE = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic bit_in,
  output logic is_multiple
);
  rem_t rem_q;
  rem_t rem_next;
  logic zero_next;

  div5_step #(.STEP_STYLE(STEP_STYLE)) u_step (
    .rem_i (rem_q),
    .bit_i (bit_in),
    .rem_o (rem_next),
    .zero_o(zero_next)
  );

  div5_state u_state (
    .clk     (clk),
    .rst     (rst),
    .en      (bit_valid),
    .rem_next(rem_next),
    .rem_q   (rem_q)
  );

  div5_flag u_flag (
    .clk      (clk),
    .rst      (rst),
    .en       (bit_valid),
    .zero_next(zero_next),
    .flag_q   (is_multiple)
  );
endmodule

// File: rtl/serial_div5_detector_chk.sv
module serial_div5_detector_chk
  import div5_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic bit_valid,
  input logic bit_in,
  input logic is_multiple,
  input rem_t rem_q
);
  // R1: reset clears the verdict
  p_reset_clears_r1: assert property (@(posedge clk) rst |=> !is_multiple && rem_q == '0);

  // R2: each accepted bit doubles the value and adds the bit
  p_append_lsb_r2: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> int'(rem_q) == ((2 * int'($past(rem_q)) + int'($past(bit_in))) % int'(MODULUS)));

  // R3: remainder never leaves its legal range
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    int'(rem_q) < int'(MODULUS));

  // R4: a high verdict always agrees with a zero remainder
  p_flag_matches_r4: assert property (@(posedge clk) disable iff (rst)
    is_multiple |-> rem_q == '0);

  // R6: idle cycles hold state and verdict
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> $stable(rem_q) && $stable(is_multiple));
endmodule

bind serial_div5_detector serial_div5_detector_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_valid  (bit_valid),
  .bit_in     (bit_in),
  .is_multiple(is_multiple),
  .rem_q      (rem_q)
);

// File: tb/serial_div5_detector_tb.sv
module serial_div5_detector_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LONG_BITS  = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic flag_a;
  logic flag_t;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  int model_r10 = 0;
  bit exp_q[$];
  string tag_q[$];
  bit last_exp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_div5_detector #(.STEP_STYLE(0)) u_dut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in), .is_multiple(flag_a));

  serial_div5_detector #(.STEP_STYLE(1)) u_dut_tbl (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in), .is_multiple(flag_t));

  task automatic check(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: value tracked modulo 10, divisible by five when last digit is 0 or 5
  task automatic send_bit(input logic b, input string tag);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_in = b;
    model_r10 = (2 * model_r10 + int'(b)) % 10;
    exp_q.push_back(model_r10 % 5 == 0);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_valid = 1'b0;
      bit_in = ~bit_in;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    bit_valid = 1'b0;
    rst = 1'b1;
    model_r10 = 0;
    @(negedge clk);
    rst = 1'b0;
    last_exp = 0;
  endtask

  // monitor
  initial begin
    forever begin
      bit took;
      bit idle_cyc;
      @(posedge clk);
      took = bit_valid && !rst;
      idle_cyc = !bit_valid && !rst;
      @(negedge clk);
      if (took) begin
        if (exp_q.size() == 0) begin
          check("R4 empty queue", 1'b1, 1'b0);
        end else begin
          bit e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          last_exp = e;
          check(t, flag_a, e);
          check({t, " R10 table"}, flag_t, e);
        end
      end else if (idle_cyc) begin
        check("R6 idle hold", flag_a, last_exp);
        check("R10 idle hold", flag_t, last_exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset flag", flag_a, 1'b0);
    check("R1 reset flag table", flag_t, 1'b0);

    // R5: documented sequence 1,0,1,0,1 -> 0,0,1,1,0
    send_bit(1, "R5 b0"); send_bit(0, "R5 b1"); send_bit(1, "R5 b2");
    send_bit(0, "R5 b3"); send_bit(1, "R5 b4");
    idle(3);

    // R7: leading zeros are divisible
    do_reset();
    send_bit(0, "R7 zero"); send_bit(0, "R7 zero2"); send_bit(1, "R7 one");
    idle(1);

    // R2 / R9: 1111 -> 1,3,7,15 back to back
    do_reset();
    send_bit(1, "R9 b2b"); send_bit(1, "R9 b2b"); send_bit(1, "R9 b2b");
    send_bit(1, "R2 fifteen");
    idle(2);

    // R6: gaps between bits of 101 -> 0,0,1
    do_reset();
    send_bit(1, "R6 gap"); idle(4); send_bit(0, "R6 gap"); idle(2);
    send_bit(1, "R6 gap five");
    idle(3);

    // R8: reset mid stream
    send_bit(1, "R8 pre"); send_bit(1, "R8 pre");
    idle(1);
    do_reset();
    check("R8 reset clears", flag_a, 1'b0);
    send_bit(1, "R8 post"); send_bit(0, "R8 post"); send_bit(1, "R8 post five");
    idle(1);

    // R3 / R4: long random stream with random idles
    do_reset();
    for (int i = 0; i < LONG_BITS; i++) begin
      send_bit(1'($urandom_range(0, 1)), "R3 long");
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 2)));
    end
    // R4: trailing zeros after a multiple stay multiples
    send_bit(0, "R4 tail"); send_bit(0, "R4 tail");
    idle(3);
    check("R4 queue drained", exp_q.size() == 0, 1'b1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule